// File: doc/BRIEF.md
# Planar Memory Read-Path Controller

This block sits between a four-plane video memory and the CPU read port. Every CPU read brings one byte from each of the four planes at the addressed location. The block captures all four bytes at once in a bank of plane latches, whatever byte the CPU asked for. At the same clock edge it registers the byte that goes back to the CPU.

That byte is formed in one of two ways. In plane-select mode it is the raw byte of one chosen plane. In colour-match mode the four bytes are read as eight 4-bit pixels. Each result bit reports whether its pixel equals a reference colour. Any plane can be left out of that comparison by a per-plane mask. The latches are also brought out for the write path, together with the write-mode field that shares the mode register.

Configuration is written through an index/data register port. Each write lands in one register, chosen by a 4-bit index. Indices that this block does not own are ignored.

Top module: `plane_read_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cpu_rdata`, `latch_q` and `wr_mode` are all zero. The reset register values are colour reference 0, plane select 0, mode 0 and pixel mask 4'hF.
- R2: When `rd_en` is high at a rising edge, all four plane latches load from `plane_data` at that edge. Plane p occupies bits [8p+7:8p] of both `plane_data` and `latch_q`.
- R3: While `rd_en` is low, `latch_q` and `cpu_rdata` keep their values.
- R4: In plane-select mode (mode register bit 3 = 0), `cpu_rdata` after a read equals the byte of the plane chosen by bits 1:0 of the plane-select register (index 4).
- R5: In colour-match mode (mode register bit 3 = 1), pixel i is built from bit i of planes 0..3, with plane p giving pixel bit p. Bit i of `cpu_rdata` is 1 exactly when (pixel AND mask) equals (reference AND mask). The reference is held at index 2, bits 3:0. The mask is held at index 7, bits 3:0.
- R6: In colour-match mode a pixel mask of 0 gives `cpu_rdata` = 8'hFF for any plane data.
- R7: A register write to index 5 sets the mode register. Bit 3 selects the read mode, and bits 1:0 appear on `wr_mode` the cycle after the write.
- R8: A register write to any index other than 2, 4, 5 or 7 changes no register.
- R9: In colour-match mode with mask 4'b0111 and reference 4'b1010, a pixel of 4'b1011 yields a result bit of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register index |
| cfg_wdata | input | 8 | Register write data |
| rd_en | input | 1 | CPU read strobe; loads latches and the return byte |
| plane_data | input | 32 | Addressed byte of each plane, plane p at [8p+7:8p] |
| cpu_rdata | output | 8 | Byte returned to the CPU |
| latch_q | output | 32 | Plane latch contents for the write path |
| wr_mode | output | 2 | Write-mode field of the mode register |

## Verification
The hardest case to reach is a colour-match result that mixes matching and non-matching pixels under a partial mask. A mixed result shows that the planes are transposed into pixels in the right order. To get there, the bench builds plane bytes from chosen per-pixel colours. It then programs the reference and mask through the index port and checks the match pattern against a model that works pixel by pixel. The example with one differing pixel and a mask of 0111 is driven directly. Reads in plane-select mode walk through all four plane choices to show the latch bank keeps every plane separate.

// File: rtl/plane_read_pkg.sv
// Package: shared sizes and register indices for the planar read path.
// Assumes four planes of one byte each; the indices are fixed by the
// register port decode.
package plane_read_pkg;
    localparam int NPLANES  = 4;
    localparam int PIXW     = 8;               // pixels per plane byte
    localparam int SELW     = $clog2(NPLANES);
    localparam int IDXW     = 4;

    localparam logic [IDXW-1:0] IDX_COLREF = 4'd2;
    localparam logic [IDXW-1:0] IDX_PLSEL  = 4'd4;
    localparam logic [IDXW-1:0] IDX_MODE   = 4'd5;
    localparam logic [IDXW-1:0] IDX_PXMASK = 4'd7;

    typedef enum logic {
        RD_PLANE = 1'b0,
        RD_MATCH = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic [NPLANES-1:0] colref;
        logic [NPLANES-1:0] pxmask;
        logic [SELW-1:0]    plsel;
        rd_mode_e           rmode;
        logic [1:0]         wmode;
    } rd_cfg_t;
endpackage

// File: rtl/plane_cfg_regs.sv
// Module: plane_cfg_regs
// Index/data register file holding the read configuration. A write
// lands on the clock edge where cfg_wr is high. Unknown indices are
// dropped. Assumes synchronous active-low reset.
module plane_cfg_regs
    import plane_read_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic [7:0]      cfg_wdata,
    output rd_cfg_t         cfg
);
    logic [1:0] unused_wbits;
    assign unused_wbits = cfg_wdata[7:6];

    // Decode the index and update one register per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.colref <= '0;
            cfg.pxmask <= '1;
            cfg.plsel  <= '0;
            cfg.rmode  <= RD_PLANE;
            cfg.wmode  <= '0;
        end else if (cfg_wr) begin
            case (cfg_idx)
                IDX_COLREF: cfg.colref <= cfg_wdata[NPLANES-1:0];
                IDX_PXMASK: cfg.pxmask <= cfg_wdata[NPLANES-1:0];
                IDX_PLSEL:  cfg.plsel  <= cfg_wdata[SELW-1:0];
                IDX_MODE: begin
                    cfg.rmode <= rd_mode_e'(cfg_wdata[3]);
                    cfg.wmode <= cfg_wdata[1:0];
                end
                default: ;
            endcase
        end
    end

    // R7
    wmode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_idx == IDX_MODE) |=> cfg.wmode == $past(cfg_wdata[1:0]));

    // R8
    foreign_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_idx != IDX_COLREF && cfg_idx != IDX_PXMASK &&
         cfg_idx != IDX_PLSEL && cfg_idx != IDX_MODE) |=> $stable(cfg));
endmodule

// File: rtl/plane_latch_bank.sv
// Module: plane_latch_bank
// One byte latch per plane. All of them load together on a read strobe.
// Assumes plane p sits at bits [8p+7:8p] of the flat bus.
module plane_latch_bank
    import plane_read_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [NPLANES*PIXW-1:0]   din,
    output logic [NPLANES*PIXW-1:0]   q
);
    for (genvar p = 0; p < NPLANES; p++) begin : g_plane
        // Capture this plane's byte on every read.
        always_ff @(posedge clk) begin
            if (!rst_n)    q[p*PIXW +: PIXW] <= '0;
            else if (load) q[p*PIXW +: PIXW] <= din[p*PIXW +: PIXW];
        end
    end

    // R2
    latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(din));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/color_match.sv
// Module: color_match
// Combinational colour compare. It transposes the plane bytes into
// pixels and flags each pixel whose masked value equals the masked
// reference.
module color_match
    import plane_read_pkg::*;
(
    input  logic [NPLANES*PIXW-1:0] planes,
    input  logic [NPLANES-1:0]      colref,
    input  logic [NPLANES-1:0]      pxmask,
    output logic [PIXW-1:0]         hit
);
    for (genvar i = 0; i < PIXW; i++) begin : g_pix
        logic [NPLANES-1:0] pix;
        for (genvar p = 0; p < NPLANES; p++) begin : g_bit
            assign pix[p] = planes[p*PIXW + i];
        end
        // Compare only the planes the mask keeps.
        always_comb hit[i] = ((pix & pxmask) == (colref & pxmask));
    end
endmodule

// File: rtl/plane_read_ctrl.sv
// Module: plane_read_ctrl (top)
// Read path of a four-plane video memory. On rd_en it loads the plane
// latches and registers the CPU return byte from the same plane data.
// Register writes take effect from the next cycle.
module plane_read_ctrl
    import plane_read_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [3:0]              cfg_idx,
    input  logic [7:0]              cfg_wdata,
    input  logic                    rd_en,
    input  logic [31:0]             plane_data,
    output logic [7:0]              cpu_rdata,
    output logic [31:0]             latch_q,
    output logic [1:0]              wr_mode
);
    rd_cfg_t         cfg;
    logic [PIXW-1:0] match_byte;
    logic [PIXW-1:0] plane_byte;
    logic [PIXW-1:0] rdata_nxt;

    plane_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg(cfg)
    );

    plane_latch_bank u_latch (
        .clk(clk), .rst_n(rst_n), .load(rd_en), .din(plane_data), .q(latch_q)
    );

    color_match u_match (
        .planes(plane_data), .colref(cfg.colref), .pxmask(cfg.pxmask),
        .hit(match_byte)
    );

    // Pick the selected plane's byte from the incoming data.
    always_comb plane_byte = plane_data[cfg.plsel*PIXW +: PIXW];

    // Choose the return byte by read mode.
    always_comb rdata_nxt = (cfg.rmode == RD_MATCH) ? match_byte : plane_byte;

    // Register the return byte together with the latch load.
    always_ff @(posedge clk) begin
        if (!rst_n)     cpu_rdata <= '0;
        else if (rd_en) cpu_rdata <= rdata_nxt;
    end

    assign wr_mode = cfg.wmode;

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(cpu_rdata));

    // R6
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cfg.rmode == RD_MATCH && cfg.pxmask == '0) |=> cpu_rdata == 8'hFF);

    // R4
    plane_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cfg.rmode == RD_PLANE) |=> cpu_rdata == latch_q[cfg.plsel*PIXW +: PIXW]);
endmodule

// File: tb/tb_plane_read_ctrl.sv
module tb_plane_read_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] plane_data = '0;
    logic [7:0]  cpu_rdata;
    logic [31:0] latch_q;
    logic [1:0]  wr_mode;

    int n_chk = 0;
    int n_fail = 0;

    plane_read_ctrl dut (.*);

    always #5 clk = ~clk;

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [31:0] pd);
        @(negedge clk);
        rd_en = 1'b1; plane_data = pd;
        @(negedge clk);
        rd_en = 1'b0; plane_data = ~pd;
    endtask

    function automatic logic [7:0] model_match(input logic [31:0] pd,
                                               input logic [3:0] ref_c,
                                               input logic [3:0] msk);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            logic [3:0] px;
            for (int p = 0; p < 4; p++) px[p] = pd[p*8 + i];
            r[i] = ((px & msk) == (ref_c & msk));
        end
        return r;
    endfunction

    task automatic t_reset();
        check("R1 rdata", cpu_rdata, 0);
        check("R1 latch", latch_q, 0);
        check("R1 wr_mode", wr_mode, 0);
        do_read(32'h11223344);
        check("R1 default plane0", cpu_rdata, 32'h44);
    endtask

    task automatic t_plane_select();
        logic [31:0] pd = 32'hA1B2C3D4;
        for (int s = 0; s < 4; s++) begin
            cfg_write(4'd4, 8'(s));
            do_read(pd);
            check("R4 plane select", cpu_rdata, (pd >> (8*s)) & 32'hFF);
            check("R2 latch load", latch_q, pd);
        end
    endtask

    task automatic t_hold();
        repeat (3) @(negedge clk);
        check("R3 latch hold", latch_q, 32'hA1B2C3D4);
        check("R3 rdata hold", cpu_rdata, 32'hA1);
    endtask

    task automatic t_mode_reg();
        cfg_write(4'd5, 8'h0B);
        check("R7 wr_mode", wr_mode, 2'b11);
        do_read(32'h0);
        check("R7 match mode active", cpu_rdata, model_match(32'h0, 4'h0, 4'hF));
    endtask

    task automatic t_match();
        logic [31:0] pats [3] = '{32'h0F0F33CC, 32'h12345678, 32'hFF00AA55};
        cfg_write(4'd2, 8'h06);
        cfg_write(4'd7, 8'h0F);
        foreach (pats[k]) begin
            do_read(pats[k]);
            check("R5 match full mask", cpu_rdata, model_match(pats[k], 4'h6, 4'hF));
            check("R2 latch in match mode", latch_q, pats[k]);
        end
        cfg_write(4'd7, 8'h05);
        do_read(32'h0F0F33CC);
        check("R5 match partial mask", cpu_rdata, model_match(32'h0F0F33CC, 4'h6, 4'h5));
    endtask

    task automatic t_mask_zero();
        cfg_write(4'd7, 8'h00);
        do_read(32'h5A3C96E1);
        check("R6 mask zero", cpu_rdata, 32'hFF);
    endtask

    task automatic t_example();
        // pixel0 = 1011, others = 0010
        cfg_write(4'd2, 8'h0A);
        cfg_write(4'd7, 8'h07);
        do_read({8'h01, 8'h00, 8'hFF, 8'h01});
        check("R9 example", cpu_rdata, 32'hFE);
    endtask

    task automatic t_foreign_idx();
        cfg_write(4'd5, 8'h00);
        cfg_write(4'd4, 8'h02);
        for (int idx = 0; idx < 16; idx++) begin
            if (idx != 2 && idx != 4 && idx != 5 && idx != 7)
                cfg_write(4'(idx), 8'hFF);
        end
        check("R8 wr_mode unchanged", wr_mode, 0);
        do_read(32'h44332211);
        check("R8 select unchanged", cpu_rdata, 32'h33);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plane_select();
        t_hold();
        t_mode_reg();
        t_match();
        t_mask_zero();
        t_example();
        t_foreign_idx();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule